// File: doc/BRIEF.md
# Line-Delay FIFO with Externally Cleared Pointers

This block is a single-clock line memory for delaying a stream of 8-bit words, such as one video line, by a controlled number of cycles. It holds 5120 words. A write pointer and a read pointer move through the memory independently. Each pointer has its own active-low clear strobe and its own active-low enable. The block has no full or empty flags. The user sets the delay by choosing the cycle in which each pointer is cleared.

Typical use starts with a write clear at the start of a line. A read clear follows some number of cycles later, and that gap becomes the delay. The read port is registered. An active-low output enable gates the result: while it is high, the data output is forced to zero.

Top module: `line_delay_fifo`

## Requirements
- R1: The memory holds 5120 words of 8 bits. Each pointer wraps from 5119 back to 0 when it advances past the last location.
- R2: In a cycle where `wr_clr_n` is low, the write address is 0. After the edge, the write pointer is 1 if `wr_en_n` was low and 0 otherwise. The clear takes priority over the enable.
- R3: At a rising edge with `wr_en_n` low, `din` is stored at the write address and the write pointer advances by one.
- R4: At a rising edge with `wr_en_n` high, nothing is stored and the write pointer keeps its value.
- R5: In a cycle where `rd_clr_n` is low, the read address is 0. After the edge, the read pointer is 1 if `rd_en_n` was low and 0 otherwise. A clear with `rd_en_n` high leaves the output unchanged.
- R6: At a rising edge with `rd_en_n` low, the word at the read address appears on the output after that edge, and the read pointer advances by one.
- R7: At a rising edge with `rd_en_n` high, the read pointer and the registered output word both hold.
- R8: While `out_en_n` is high, `dout` is all zeros. While it is low, `dout` shows the registered read word. The gating is combinational and takes effect with no clock edge.
- R9: A read returns the word written to that location, provided that word was written at least 20 write cycles earlier. When the write pointer minus the read pointer is between 1 and 19, the result is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| din | input | 8 | Word to store |
| wr_en_n | input | 1 | Write enable, active low |
| wr_clr_n | input | 1 | Write pointer clear strobe, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_clr_n | input | 1 | Read pointer clear strobe, active low |
| out_en_n | input | 1 | Output enable, active low; high forces zero |
| dout | output | 8 | Registered read word, gated by output enable |

## Verification
The bench fills the full 5120-word line and then keeps writing past the end. It reads back across the wrap to confirm the overwritten first words. A pointer that failed to wrap, or wrapped one location early, would misplace every word after location 5119. Clears issued with the enable high check that the pointer settles at zero without storing or reading. A design that applied the enable before the clear would start one word off. The bench also runs continuous delay lines at exactly 20 cycles of separation and at a wider gap. A read port that returned data one cycle early or late, or that did not hold while disabled, would shift or change the delayed stream.

// File: rtl/lfifo_pkg.sv
package lfifo_pkg;

  // Advance an address by one with wrap at the last location.
  function automatic int unsigned addr_step(input int unsigned a,
                                            input int unsigned depth);
    return (a >= depth - 1) ? 0 : a + 1;
  endfunction

  // Effective address for a cycle: a clear strobe forces zero.
  function automatic int unsigned addr_eff(input int unsigned ptr,
                                           input logic clr_n);
    return clr_n ? ptr : 0;
  endfunction

endpackage

// File: rtl/lfifo_ptr.sv
module lfifo_ptr #(
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          en_n,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q = '0;

  always_comb addr = AW'(lfifo_pkg::addr_eff(int'(ptr_q), clr_n));

  always_ff @(posedge clk) begin
    if (!en_n) ptr_q <= AW'(lfifo_pkg::addr_step(int'(addr), DEPTH));
    else       ptr_q <= addr;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/lfifo_ram.sv
module lfifo_ram #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q = '0;

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lfifo_gate.sv
module lfifo_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign q[b] = word[b] & ~oe_n;
  end
endmodule

// File: rtl/line_delay_fifo.sv
module line_delay_fifo #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  input  logic             wr_en_n,
  input  logic             wr_clr_n,
  input  logic             rd_en_n,
  input  logic             rd_clr_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned AW = $clog2(DEPTH);

  // Named internal events for the checker.
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [WIDTH-1:0] rd_word;
  logic             wr_fire, rd_fire;

  assign wr_fire = ~wr_en_n;
  assign rd_fire = ~rd_en_n;

  lfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .clr_n(wr_clr_n), .en_n(wr_en_n), .addr(wr_addr), .ptr(wr_ptr)
  );

  lfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .clr_n(rd_clr_n), .en_n(rd_en_n), .addr(rd_addr), .ptr(rd_ptr)
  );

  lfifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .wr(wr_fire), .waddr(wr_addr), .wdata(din),
    .rd(rd_fire), .raddr(rd_addr), .rdata(rd_word)
  );

  lfifo_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n(out_en_n), .word(rd_word), .q(dout)
  );
endmodule

// File: rtl/lfifo_checker.sv
module lfifo_checker #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             wr_en_n,
  input logic             wr_clr_n,
  input logic             rd_en_n,
  input logic             rd_clr_n,
  input logic             out_en_n,
  input logic [WIDTH-1:0] dout,
  input logic [AW-1:0]    wr_ptr,
  input logic [AW-1:0]    rd_ptr,
  input logic [WIDTH-1:0] rd_word
);
  logic w_live = 1'b0;
  logic r_live = 1'b0;

  always_ff @(posedge clk) begin
    if (!wr_clr_n) w_live <= 1'b1;
    if (!rd_clr_n) r_live <= 1'b1;
  end

  AST_WPTR_RANGE: assert property (@(posedge clk) disable iff (!w_live)
    32'(wr_ptr) < DEPTH); // R1
  AST_WCLR_IDLE: assert property (@(posedge clk) disable iff (!w_live)
    (!wr_clr_n && wr_en_n) |=> wr_ptr == '0); // R2
  AST_WCLR_GO: assert property (@(posedge clk) disable iff (!w_live)
    (!wr_clr_n && !wr_en_n) |=> 32'(wr_ptr) == (DEPTH > 1 ? 1 : 0)); // R2
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!w_live)
    (wr_clr_n && !wr_en_n) |=>
      32'(wr_ptr) == (32'($past(wr_ptr)) + 1) % DEPTH); // R3
  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!w_live)
    (wr_clr_n && wr_en_n) |=> $stable(wr_ptr)); // R4
  AST_RCLR_IDLE: assert property (@(posedge clk) disable iff (!r_live)
    (!rd_clr_n && rd_en_n) |=> rd_ptr == '0 && $stable(rd_word)); // R5
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!r_live)
    (rd_clr_n && !rd_en_n) |=>
      32'(rd_ptr) == (32'($past(rd_ptr)) + 1) % DEPTH); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!r_live)
    (rd_clr_n && rd_en_n) |=> $stable(rd_ptr) && $stable(rd_word)); // R7

  always_comb begin
    if (out_en_n) AST_OE_ZERO: assert (dout == '0); // R8
    else          AST_OE_PASS: assert (dout == rd_word); // R8
  end
endmodule

bind line_delay_fifo lfifo_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n), .rd_en_n(rd_en_n),
  .rd_clr_n(rd_clr_n), .out_en_n(out_en_n), .dout(dout),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_word(rd_word)
);

// File: tb/sim_line_delay_fifo.sv
`timescale 1ns/1ps
module sim_line_delay_fifo;
  localparam int DEPTH = 5120;
  localparam int TAIL  = 10;

  logic       clk = 1'b0;
  logic [7:0] din = '0;
  logic       wr_en_n = 1'b1, wr_clr_n = 1'b1;
  logic       rd_en_n = 1'b1, rd_clr_n = 1'b1;
  logic       out_en_n = 1'b0;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_delay_fifo u0 (
    .clk(clk), .din(din), .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n),
    .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n), .out_en_n(out_en_n), .dout(dout)
  );

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] pat_b(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat_c(input int i);
    return 8'(((i * 13 + 5) ^ 8'h33) & 255);
  endfunction
  // Expected line contents after the first fill plus wrapped tail.
  function automatic logic [7:0] line_exp(input int a);
    return (a < TAIL) ? pat_b(a) : pat_a(a);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic delay_line(input int gap, input int count);
    for (int c = 0; c < gap + count; c++) begin
      wr_clr_n = (c == 0) ? 1'b0 : 1'b1;
      wr_en_n  = 1'b0;
      din      = pat_c(c);
      rd_clr_n = (c == gap) ? 1'b0 : 1'b1;
      rd_en_n  = (c >= gap) ? 1'b0 : 1'b1;
      tick();
      if (c >= gap) chk("R9 delay line", dout, pat_c(c - gap));
    end
    wr_en_n = 1'b1; rd_en_n = 1'b1; wr_clr_n = 1'b1; rd_clr_n = 1'b1;
  endtask

  initial begin
    logic [7:0] held;
    tick();
    chk("R8 idle output enabled", dout, 8'h00);

    // Fill the whole line, then wrap and overwrite the first TAIL words (R1, R2, R3).
    for (int i = 0; i < DEPTH + TAIL; i++) begin
      wr_clr_n = (i == 0) ? 1'b0 : 1'b1;
      wr_en_n  = 1'b0;
      din      = (i < DEPTH) ? pat_a(i) : pat_b(i - DEPTH);
      tick();
    end
    wr_en_n = 1'b1; wr_clr_n = 1'b1;

    // Read the full line and across the wrap (R1, R5, R6).
    for (int i = 0; i < DEPTH + TAIL; i++) begin
      rd_clr_n = (i == 0) ? 1'b0 : 1'b1;
      rd_en_n  = 1'b0;
      tick();
      if (i >= DEPTH)      chk("R1 read wrap",  dout, line_exp(i - DEPTH));
      else if (i < TAIL)   chk("R1 write wrap", dout, line_exp(i));
      else                 chk("R6 read",       dout, line_exp(i));
    end
    rd_en_n = 1'b1; rd_clr_n = 1'b1;

    // Hold while disabled, with din changing and writes disabled (R7, R4).
    held = dout;
    for (int i = 0; i < 30; i++) begin
      din = 8'(i * 31 + 1);
      tick();
      chk("R7 output hold", dout, held);
    end
    for (int i = 0; i < 30; i++) begin
      rd_clr_n = (i == 0) ? 1'b0 : 1'b1;
      rd_en_n  = 1'b0;
      tick();
      chk("R4 disabled write ignored", dout, line_exp(i));
    end
    rd_en_n = 1'b1; rd_clr_n = 1'b1;

    // Output enable gating, combinational (R8).
    held = dout;
    out_en_n = 1'b1; #1;
    chk("R8 gated zero", dout, 8'h00);
    out_en_n = 1'b0; #1;
    chk("R8 ungated", dout, held);

    // Read pointer hold across a pause (R7).
    for (int i = 0; i < 5; i++) begin
      rd_clr_n = (i == 0) ? 1'b0 : 1'b1;
      rd_en_n = 1'b0;
      tick();
    end
    rd_en_n = 1'b1; rd_clr_n = 1'b1;
    tick(); tick(); tick();
    for (int i = 5; i < 8; i++) begin
      rd_en_n = 1'b0;
      tick();
      chk("R7 pointer hold", dout, line_exp(i));
    end
    rd_en_n = 1'b1;

    // Clear with enable high: no store, pointer at zero (R2).
    wr_clr_n = 1'b0; wr_en_n = 1'b1; din = 8'hEE;
    tick();
    wr_clr_n = 1'b1; wr_en_n = 1'b0; din = 8'hC1;
    tick();
    din = 8'hC2;
    tick();
    wr_en_n = 1'b1;
    // Read clear with enable high: output unchanged, pointer at zero (R5).
    held = dout;
    rd_clr_n = 1'b0; rd_en_n = 1'b1;
    tick();
    chk("R5 idle clear keeps output", dout, held);
    rd_clr_n = 1'b1; rd_en_n = 1'b0;
    tick();
    chk("R2 idle clear then write at 0", dout, 8'hC1);
    tick();
    chk("R5 idle clear then read at 1", dout, 8'hC2);
    tick();
    chk("R4 clear did not write", dout, line_exp(2));
    rd_en_n = 1'b1;

    // Streaming delay lines at the minimum and a wider separation (R9).
    delay_line(20, 120);
    delay_line(45, 120);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule